// File: doc/BRIEF.md
# Registered Octal Bus Transceiver

This block links two 8-bit buses, called side A and side B. Data can pass in either direction, or in both at once. Each direction has a storage register and an output enable. A per-direction select decides what the driven side carries. It is either the live value on the opposite bus or the copy held in that direction's register. The A register captures bus A on a rising edge of its own capture clock. The B register captures bus B on a rising edge of a second, independent clock. Capture happens whatever the select levels are.

The bus pads are not modelled as inout ports. Each side has a separate input vector, a driven-value vector and a per-bit output-enable vector, and the surrounding logic resolves the shared wire. An undriven side has its enables low. The two selects are built from a hazard-covered multiplexer. A select change therefore cannot disturb an output bit whose live and stored values agree.

When both selects pick live data and both directions are enabled, each side drives the other. The buses then keep their last value after every other driver lets go.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, both storage registers clear to zero. After release, a stored-select output reads 0.
- R2: A rising edge of `clk_a` loads `a_in` into the A register, whatever the levels of `sel_a2b` and `sel_b2a`.
- R3: A rising edge of `clk_b` loads `b_in` into the B register. A capture on one clock leaves the other register unchanged.
- R4: With `sel_a2b` = 0, `b_out` equals `a_in` bit for bit, without inversion. With `sel_a2b` = 1, `b_out` equals the A register.
- R5: With `sel_b2a` = 0, `a_out` equals `b_in`. With `sel_b2a` = 1, `a_out` equals the B register.
- R6: `en_a2b` is active high. When it is 1, every bit of `b_oe` is 1. When it is 0, every bit is 0 and side B is undriven.
- R7: `en_b2a_n` is active low. When it is 0, every bit of `a_oe` is 1. When it is 1, every bit is 0 and side A is undriven.
- R8: A select can toggle any number of times. Throughout, output bits whose live and stored values are equal do not change.
- R9: Set both selects to 0 and enable both directions. Once every external driver releases both buses, each bus keeps its last value.
- R10: Changes on `a_in` or `b_in` without the matching capture edge do not alter the stored values, including when the other clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, clears both registers |
| clk_a | input | 1 | Capture clock for the A register (rising edge) |
| clk_b | input | 1 | Capture clock for the B register (rising edge) |
| en_a2b | input | 1 | Drive enable for side B, active high |
| en_b2a_n | input | 1 | Drive enable for side A, active low |
| sel_a2b | input | 1 | Side B source: 0 live bus A, 1 A register |
| sel_b2a | input | 1 | Side A source: 0 live bus B, 1 B register |
| a_in | input | 8 | Resolved value seen on bus A |
| a_out | output | 8 | Value the block offers to bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Resolved value seen on bus B |
| b_out | output | 8 | Value the block offers to bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
Two functions can land in the same instant. One is a capture into a register. The other is that register's content appearing on the opposite side while the select picks stored data. The bench loads a register while the select is high and the enable is active, then confirms the new value after the edge and the old value before it. It also toggles a select while live and stored values share some bits, and counts every change on those shared bits. Finally, the bench runs a resolved-bus model in which the two directions feed each other. It releases the external drivers there and confirms that both buses keep their values.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Source chosen for a driven side
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;

   // Polarity of a drive-enable pin
   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } pol_e;

   function automatic logic pin_active(input logic pin, input pol_e pol);
      return (pol == POL_HIGH) ? pin : ~pin;
   endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             cap_clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_capture_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
   parameter int WIDTH        = 8,
   parameter bit HAZARD_COVER = 1'b1
) (
   input  xcvr_pkg::src_e   sel,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] y
);
   import xcvr_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_src_mux: WIDTH must be at least 1");
   end

   logic s;
   assign s = (sel == SRC_STORED);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (HAZARD_COVER) begin : g_cover
         // consensus term keeps the bit steady when both inputs agree
         assign y[i] = (s & stored[i]) | (~s & live[i]) | (stored[i] & live[i]);
      end else begin : g_plain
         assign y[i] = s ? stored[i] : live[i];
      end
   end

endmodule

// File: rtl/xcvr_side_drv.sv
module xcvr_side_drv #(
   parameter int             WIDTH = 8,
   parameter xcvr_pkg::pol_e EN_POL = xcvr_pkg::POL_HIGH
) (
   input  logic             en_pin,
   input  logic [WIDTH-1:0] val,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   import xcvr_pkg::*;

   logic active;

   if (EN_POL == POL_HIGH) begin : g_hi
      assign active = en_pin;
   end else begin : g_lo
      assign active = pin_active(en_pin, POL_LOW);
   end

   assign pad_out = val;
   assign pad_oe  = {WIDTH{active}};

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
   parameter int WIDTH        = 8,
   parameter bit HAZARD_COVER = 1'b1
) (
   input  logic             rst_n,
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             en_a2b,
   input  logic             en_b2a_n,
   input  logic             sel_a2b,
   input  logic             sel_b2a,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);
   import xcvr_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("bus_xcvr_reg: WIDTH must be at least 1");
   end

   logic [MSB:0] reg_a_q, reg_b_q;
   logic [MSB:0] to_b, to_a;
   src_e         src_a2b, src_b2a;

   assign src_a2b = sel_a2b ? SRC_STORED : SRC_LIVE;
   assign src_b2a = sel_b2a ? SRC_STORED : SRC_LIVE;

   xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_a (
      .rst_n(rst_n), .cap_clk(clk_a), .d(a_in), .q(reg_a_q));

   xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_b (
      .rst_n(rst_n), .cap_clk(clk_b), .d(b_in), .q(reg_b_q));

   xcvr_src_mux #(.WIDTH(WIDTH), .HAZARD_COVER(HAZARD_COVER)) u_mux_a2b (
      .sel(src_a2b), .live(a_in), .stored(reg_a_q), .y(to_b));

   xcvr_src_mux #(.WIDTH(WIDTH), .HAZARD_COVER(HAZARD_COVER)) u_mux_b2a (
      .sel(src_b2a), .live(b_in), .stored(reg_b_q), .y(to_a));

   xcvr_side_drv #(.WIDTH(WIDTH), .EN_POL(POL_HIGH)) u_drv_b (
      .en_pin(en_a2b), .val(to_b), .pad_out(b_out), .pad_oe(b_oe));

   xcvr_side_drv #(.WIDTH(WIDTH), .EN_POL(POL_LOW)) u_drv_a (
      .en_pin(en_b2a_n), .val(to_a), .pad_out(a_out), .pad_oe(a_oe));

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             rst_n,
   input logic             clk_a,
   input logic             clk_b,
   input logic             en_a2b,
   input logic             en_b2a_n,
   input logic             sel_a2b,
   input logic             sel_b2a,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_oe
);

   // R2
   cap_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      ($past(rst_n) && sel_a2b) |-> (b_out == $past(a_in)));

   // R3
   cap_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      ($past(rst_n) && sel_b2a) |-> (a_out == $past(b_in)));

   // R4
   live_a2b_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      !sel_a2b |-> (b_out == a_in));

   // R5
   live_b2a_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      !sel_b2a |-> (a_out == b_in));

   // R6
   oe_b_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
      en_a2b ? (b_oe == '1) : (b_oe == '0));

   // R7
   oe_a_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
      en_b2a_n ? (a_oe == '0) : (a_oe == '1));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .en_a2b(en_a2b),
   .en_b2a_n(en_b2a_n), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
   .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
   .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/1ps
module bus_xcvr_reg_test;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, clk_a = 1'b0, clk_b = 1'b0;
   logic en_a2b = 1'b0, en_b2a_n = 1'b1, sel_a2b = 1'b1, sel_b2a = 1'b1;
   logic [W-1:0] a_bus = '0, b_bus = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic [W-1:0] ext_a = '0, ext_b = '0;
   logic ext_a_en = 1'b1, ext_b_en = 1'b1;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 1'b0;

   bus_xcvr_reg #(.WIDTH(W)) uut (
      .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .en_a2b(en_a2b),
      .en_b2a_n(en_b2a_n), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
      .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_bus), .b_out(b_out), .b_oe(b_oe));

   // resolved-bus model: external driver wins, else block drive, else pull-down
   always begin
      #1;
      a_bus = ext_a_en ? ext_a : (a_out & a_oe);
      b_bus = ext_b_en ? ext_b : (b_out & b_oe);
   end

   // glitch monitor on masked bits of b_out
   logic [W-1:0] gl_mask = '0, gl_prev = '0;
   int gl_events = 0;
   always @(b_out) begin
      if (((b_out ^ gl_prev) & gl_mask) != '0) gl_events++;
      gl_prev = b_out;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      #6;
   endtask

   task automatic pulse_a();
      clk_a = 1'b1; #2; clk_a = 1'b0; #2;
   endtask

   task automatic pulse_b();
      clk_b = 1'b1; #2; clk_b = 1'b0; #2;
   endtask

   task automatic t_reset();
      ext_a = 8'hA5; ext_b = 8'h5A; ext_a_en = 1; ext_b_en = 1;
      sel_a2b = 1; sel_b2a = 1;
      settle();
      pulse_a(); pulse_b();   // edges during reset are ignored
      rst_n = 1'b1; settle();
      check("R1 A reg after reset", b_out, 8'h00);
      check("R1 B reg after reset", a_out, 8'h00);
   endtask

   task automatic t_enables();
      en_a2b = 1; en_b2a_n = 1; settle();
      check("R6 b_oe enabled", b_oe, 8'hFF);
      check("R7 a_oe disabled", a_oe, 8'h00);
      en_a2b = 0; en_b2a_n = 0; settle();
      check("R6 b_oe disabled", b_oe, 8'h00);
      check("R7 a_oe enabled", a_oe, 8'hFF);
      en_b2a_n = 1; settle();
   endtask

   task automatic t_live();
      sel_a2b = 0; sel_b2a = 0;
      ext_a = 8'h3C; ext_b = 8'h81; settle();
      check("R4 live a->b", b_out, 8'h3C);
      check("R5 live b->a", a_out, 8'h81);
      ext_a = 8'hE7; ext_b = 8'h42; settle();
      check("R4 live a->b second", b_out, 8'hE7);
      check("R5 live b->a second", a_out, 8'h42);
   endtask

   task automatic t_capture();
      sel_a2b = 0; sel_b2a = 1;   // A capture with its select low
      ext_a = 8'h96; settle(); pulse_a();
      sel_a2b = 1; settle();
      check("R2 A reg loaded with select low", b_out, 8'h96);
      check("R3 B reg untouched by clk_a", a_out, 8'h00);
      en_a2b = 1; ext_a = 8'h1F; settle();
      check("R2 stored before edge", b_out, 8'h96);
      pulse_a(); settle();
      check("R2 stored after edge", b_out, 8'h1F);
      en_a2b = 0;
      ext_b = 8'hD2; settle(); pulse_b(); settle();
      check("R3 B reg loaded", a_out, 8'hD2);
      check("R3 A reg untouched by clk_b", b_out, 8'h1F);
   endtask

   task automatic t_no_edge();
      ext_a = 8'h22; ext_b = 8'h77; settle();
      pulse_b(); settle();
      check("R10 A reg ignores a_in without clk_a", b_out, 8'h1F);
      ext_b = 8'h00; settle(); pulse_a(); ext_a = 8'hFF; settle();
      check("R10 B reg ignores b_in without clk_b", a_out, 8'h77);
   endtask

   task automatic t_glitch();
      ext_a = 8'hF0; settle(); pulse_a();
      ext_a = 8'hFF; sel_a2b = 1; settle();
      gl_prev = b_out; gl_mask = 8'hF0; gl_events = 0;
      for (int k = 0; k < 6; k++) begin
         sel_a2b = ~sel_a2b; #3;
      end
      settle();
      checks++;
      if (gl_events != 0) begin
         failures++;
         $display("FAIL R8 shared bits changed actual=%0d expected=0", gl_events);
      end
      gl_mask = '0;
      check("R8 final stored value", b_out, 8'hF0);
      sel_a2b = 0; settle();
      check("R8 live after toggles", b_out, 8'hFF);
   endtask

   task automatic t_hold();
      sel_a2b = 0; sel_b2a = 0; en_a2b = 1; en_b2a_n = 0;
      ext_a = 8'h5A; ext_a_en = 1; ext_b_en = 0; settle();
      ext_a_en = 0; #20;
      check("R9 bus A holds", a_bus, 8'h5A);
      check("R9 bus B holds", b_bus, 8'h5A);
      ext_b = 8'hC3; ext_b_en = 1; settle();
      ext_b_en = 0; #20;
      check("R9 bus A holds new", a_bus, 8'hC3);
      check("R9 bus B holds new", b_bus, 8'hC3);
   endtask

   initial begin
      t_reset();
      t_enables();
      t_live();
      t_capture();
      t_no_edge();
      t_glitch();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule